// File: doc/BRIEF.md
# Dual Sigma-Delta DAC Modulator

This block turns two 16-bit digital codes into two one-bit pulse streams. An external RC low-pass filter smooths each stream into an analog level. Each channel keeps a 16-bit phase accumulator. The accumulator adds the channel's code once per modulator tick, and the carry out of that addition is the bit driven on the pin. Because the output is a carry and not a counter compare, the high ticks are spread as evenly as possible across the 65536-tick frame. The ripple that reaches the filter is therefore small and high in frequency.

Both channels share one tick generator. A prescaler divides the system clock by 1, 2, 4 or 8, and a run input freezes the whole block when it is low. Software-side logic writes a code through a simple write port. The code waits in a holding register and moves into the active code register only on a tick, so the accumulator always adds a whole value. A mode input selects one of two output formats. In non-return-to-zero format the pin holds the carry for the whole tick. In return-to-zero format every high tick is cut to its first half. This makes each pulse independent of edge asymmetry, at the cost of half the full-scale output.

Low-order code bits that are written as zero shorten the repeat period. With four zero bits the pattern repeats every 4096 ticks, and with eight zero bits it repeats every 256 ticks. This gives a faster, coarser converter without any change to the block.

Top module: `sd_dac_dual`

## Requirements
- R1: With a fixed code on a channel, its output is high in exactly `code` ticks of any 65536 consecutive ticks. Code 0 never goes high, and code 0xFFFF goes high in 65535 of them.
- R2: Each tick adds the active code to the channel's 16-bit accumulator, and the carry of that sum is the new output bit. In non-return-to-zero format the output changes only on the clock edge that carries a tick. A tick falls on every div-th clock edge on which run is high, counted from the internal reset release.
- R3: With code 0x4010 and divide 1, consecutive high ticks on the output are always 4 or 3 ticks apart, and at least one gap of 3 occurs in a 65536-tick frame.
- R4: The two channels share the tick but have separate codes and accumulators, so one channel's code never changes the other channel's output.
- R5: In return-to-zero format with a divide of 2 or more, a tick whose carry is 1 drives the output high for the first div/2 clocks of the tick and low for the rest. A tick whose carry is 0 stays low.
- R6: div_sel values 0, 1, 2 and 3 select a divide of 1, 2, 4 and 8. Return-to-zero format with divide 1 behaves exactly like non-return-to-zero. div_sel and rz_mode are changed only while reset is held.
- R7: A code whose low 4 bits are zero repeats every 4096 ticks with code>>4 highs per period. A code whose low 8 bits are zero repeats every 256 ticks with code>>8 highs per period.
- R8: A write with wr_en high stores wr_data for channel wr_chan (0 or 1) in a holding register. The next tick copies it into the active code register, and the tick after that is the first one that adds it.
- R9: An asserted rst_n clears both accumulators, all code registers and the prescaler, and forces both outputs low at once. Release passes through a two-stage synchronizer, so the core leaves reset on the second clock edge after rst_n rises.
- R10: While run is low, no tick occurs, and the prescaler phase, the accumulators and both outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Enables the prescaler; low freezes the block |
| div_sel | input | 2 | Prescaler select: divide by 1, 2, 4 or 8 |
| rz_mode | input | 1 | 1 selects return-to-zero output, 0 non-return-to-zero |
| wr_en | input | 1 | Code write strobe |
| wr_chan | input | 1 | Channel addressed by the write |
| wr_data | input | 16 | Code value written to the holding register |
| dac_out | output | 2 | One-bit output stream per channel, bit i for channel i |

## Verification
The output is registered. A tick on edge E is visible just after E, and a return-to-zero pulse falls on the edge div/2 clocks after the tick edge. A write sampled on edge E first shapes the carry two ticks later, and the core starts counting on the second edge after reset release. A cycle-level model in the bench, driven by these rules, queues one expected output pair at every rising edge. A monitor pops that pair 1 ns after the same edge and compares it with the pins. The window checks for duty, spacing, periods, return-to-zero pulse width and freeze sample the pins at the same point, so each result is read in the cycle in which it is due.

// File: rtl/sd_dac_pkg.sv
package sd_dac_pkg;
  localparam int unsigned DAC_CODE_W = 16;
  localparam int unsigned DAC_NCH    = 2;
  localparam int unsigned DAC_SEL_W  = 2;

  typedef enum logic [1:0] {
    DIV_BY_1 = 2'd0,
    DIV_BY_2 = 2'd1,
    DIV_BY_4 = 2'd2,
    DIV_BY_8 = 2'd3
  } div_sel_e;
endpackage

// File: rtl/sd_dac_prescaler.sv
module sd_dac_prescaler #(
  parameter int SEL_W = 2,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             rz_en,
  output logic             tick,
  output logic             rz_cut,
  output logic             phase_zero
);
  logic [CNT_W-1:0] cnt_q, cnt_d, last_cnt, half_cnt;

  always_comb begin
    last_cnt = CNT_W'((32'd1 << div_sel) - 32'd1);
    half_cnt = CNT_W'((32'd1 << div_sel) >> 1);
    tick     = run && (cnt_q == last_cnt);
    if (!run)      cnt_d = cnt_q;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CNT_W'(1);
    // second half of the tick that follows this edge
    rz_cut     = rz_en && (cnt_d >= half_cnt);
    phase_zero = (cnt_q == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: a stopped prescaler keeps its phase
  p_phase_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(cnt_q));
endmodule

// File: rtl/sd_dac_channel.sv
module sd_dac_channel #(
  parameter int CODE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              tick,
  input  logic              rz_cut,
  output logic              out
);
  logic [CODE_W-1:0] hold_q, hold_d;
  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] acc_q, acc_d;
  logic              carry_q, carry_d;
  logic              out_q, out_d;
  logic [CODE_W:0]   sum;

  always_comb begin
    sum     = {1'b0, acc_q} + {1'b0, code_q};
    hold_d  = wr ? wdata : hold_q;
    code_d  = tick ? hold_q : code_q;
    acc_d   = tick ? sum[CODE_W-1:0] : acc_q;
    carry_d = tick ? sum[CODE_W] : carry_q;
    out_d   = carry_d && !rz_cut;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      code_q  <= '0;
      acc_q   <= '0;
      carry_q <= 1'b0;
      out_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      code_q  <= code_d;
      acc_q   <= acc_d;
      carry_q <= carry_d;
      out_q   <= out_d;
    end
  end

  assign out = out_q;

  p_carry_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(carry_q) && $stable(acc_q));
  p_code_from_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> code_q == $past(hold_q));
  p_zero_code_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && code_q == '0) |=> !carry_q);
  p_full_code_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (&code_q) && acc_q != '0) |=> carry_q);
endmodule

// File: rtl/sd_dac_dual.sv
module sd_dac_dual #(
  parameter int CODE_W = sd_dac_pkg::DAC_CODE_W,
  parameter int NCH    = sd_dac_pkg::DAC_NCH,
  parameter int SEL_W  = sd_dac_pkg::DAC_SEL_W,
  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [SEL_W-1:0]  div_sel,
  input  logic              rz_mode,
  input  logic              wr_en,
  input  logic [CH_W-1:0]   wr_chan,
  input  logic [CODE_W-1:0] wr_data,
  output logic [NCH-1:0]    dac_out
);
  logic [1:0] rsync_q;
  logic       core_rst_n;
  logic       tick, rz_cut, phase_zero, rz_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign core_rst_n = rsync_q[1];

  // divide by 1 has no mid-tick edge: return-to-zero falls back to NRZ
  assign rz_en = rz_mode && (div_sel != '0);

  sd_dac_prescaler #(.SEL_W(SEL_W)) u_psc (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .run        (run),
    .div_sel    (div_sel),
    .rz_en      (rz_en),
    .tick       (tick),
    .rz_cut     (rz_cut),
    .phase_zero (phase_zero)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ch_wr;
    assign ch_wr = wr_en && (wr_chan == CH_W'(i));

    sd_dac_channel #(.CODE_W(CODE_W)) u_ch (
      .clk    (clk),
      .rst_n  (core_rst_n),
      .wr     (ch_wr),
      .wdata  (wr_data),
      .tick   (tick),
      .rz_cut (rz_cut),
      .out    (dac_out[i])
    );

    // R2: a pulse starts only at the start of a tick
    p_rise_at_tick_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
      $rose(dac_out[i]) |-> phase_zero);
  end
endmodule

// File: tb/sd_dac_dual_test.sv
module sd_dac_dual_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run;
  logic [1:0]  div_sel;
  logic        rz_mode;
  logic        wr_en;
  logic [0:0]  wr_chan;
  logic [15:0] wr_data;
  logic [1:0]  dac_out;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  sd_dac_dual uut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_sel(div_sel), .rz_mode(rz_mode),
    .wr_en(wr_en), .wr_chan(wr_chan), .wr_data(wr_data), .dac_out(dac_out)
  );

  typedef struct { logic [1:0] v; bit rz; } exp_t;
  exp_t exp_q[$];

  // cycle model built from R2, R5, R6, R8, R9, R10
  logic [1:0]  m_rs = 2'b00;
  int          m_cnt = 0;
  logic [15:0] m_acc [2];
  logic [15:0] m_code[2];
  logic [15:0] m_hold[2];
  logic        m_car [2];
  bit          m_live = 0;

  task automatic m_clear();
    m_cnt = 0;
    for (int c = 0; c < 2; c++) begin
      m_acc[c] = 0; m_code[c] = 0; m_hold[c] = 0; m_car[c] = 0;
    end
  endtask

  always @(posedge clk) begin
    exp_t e;
    int div;
    logic [16:0] s;
    if (m_live) begin
      div = 1 << div_sel;
      if (!rst_n) begin
        m_rs = 2'b00; m_clear();
      end else if (!m_rs[1]) begin
        m_rs = {m_rs[0], 1'b1}; m_clear();
      end else begin
        if (run) begin
          if (m_cnt == div - 1) begin
            for (int c = 0; c < 2; c++) begin
              s = {1'b0, m_acc[c]} + {1'b0, m_code[c]};
              m_acc[c] = s[15:0]; m_car[c] = s[16]; m_code[c] = m_hold[c];
            end
            m_cnt = 0;
          end else m_cnt++;
        end
        if (wr_en) m_hold[wr_chan] = wr_data;
      end
      e.rz = rz_mode && div > 1;
      for (int c = 0; c < 2; c++)
        e.v[c] = m_car[c] && !(e.rz && m_cnt >= div / 2);
      exp_q.push_back(e);
    end
  end

  always begin
    exp_t e;
    @(posedge clk); #1;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (dac_out !== e.v) begin
        fails++;
        $display("FAIL %s scoreboard t=%0t actual=%b expected=%b",
                 e.rz ? "R5" : "R2", $time, dac_out, e.v);
      end
    end
  end

  task automatic check(input string req, input int act, input int expv, input string what);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic do_reset(input logic [1:0] sel, input logic rz);
    @(negedge clk);
    rst_n = 1'b0; div_sel = sel; rz_mode = rz; wr_en = 1'b0; run = 1'b1;
    repeat (3) @(negedge clk);
    check("R9", dac_out, 0, "outputs during reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9", dac_out, 0, "outputs after release");
  endtask

  task automatic write_code(input int ch, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_chan = 1'(ch); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts high samples per channel; gap statistics on channel 0
  task automatic measure(input int n, output int h0, output int h1,
                         output int bad_gap, output int short_gap);
    int last = -1;
    h0 = 0; h1 = 0; bad_gap = 0; short_gap = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (dac_out[1]) h1++;
      if (dac_out[0]) begin
        h0++;
        if (last >= 0) begin
          if (i - last == 3) short_gap++;
          else if (i - last != 4) bad_gap++;
        end
        last = i;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    int h0, h1, bg, sg;
    logic [1:0] held;
    rst_n = 1'b0; run = 1'b0; div_sel = 2'd0; rz_mode = 1'b0;
    wr_en = 1'b0; wr_chan = 1'b0; wr_data = 16'h0;
    m_clear();
    @(negedge clk);
    m_live = 1;

    // R8: write timing at divide 1, accumulators at zero
    do_reset(2'd0, 1'b0);
    write_code(0, 16'hFFFF);
    @(posedge clk); #1;
    @(posedge clk); #1;
    check("R8", dac_out[0], 0, "no carry on first tick using new code");
    @(posedge clk); #1;
    check("R8", dac_out[0], 1, "carry on second tick using new code");
    @(negedge clk);

    // R1, R3, R4: full frame at divide 1
    write_code(0, 16'h4010);
    write_code(1, 16'hFFFF);
    repeat (4) @(negedge clk);
    measure(65536, h0, h1, bg, sg);
    check("R1", h0, 16'h4010, "ch0 highs per frame");
    check("R1", h1, 65535, "ch1 highs per frame code FFFF");
    check("R3", bg, 0, "ch0 gaps other than 3 or 4");
    check("R3", (sg > 0) ? 1 : 0, 1, "ch0 short gap present");
    check("R4", h0 + h1, 16'h4010 + 65535, "channels independent");

    // R7 and zero code
    write_code(0, 16'h0000);
    write_code(1, 16'h1230);
    repeat (4) @(negedge clk);
    measure(4096, h0, h1, bg, sg);
    check("R1", h0, 0, "code 0 never high");
    check("R7", h1, 16'h123, "12-bit period highs");
    write_code(1, 16'hA500);
    repeat (4) @(negedge clk);
    measure(256, h0, h1, bg, sg);
    check("R7", h1, 16'hA5, "8-bit period highs");

    // R5: return-to-zero at divide 4
    do_reset(2'd2, 1'b1);
    write_code(0, 16'h8000);
    write_code(1, 16'h4000);
    repeat (20) @(negedge clk);
    measure(256, h0, h1, bg, sg);
    check("R5", h0, 64, "RZ high clocks ch0");
    check("R5", h1, 32, "RZ high clocks ch1");

    // R10: freeze
    repeat (3) @(negedge clk);
    run = 1'b0;
    held = dac_out;
    repeat (30) begin
      @(negedge clk);
      check("R10", dac_out, held, "output held while stopped");
    end
    run = 1'b1;
    repeat (20) @(negedge clk);

    // R6: return-to-zero ignored at divide 1
    do_reset(2'd0, 1'b1);
    write_code(0, 16'h8000);
    repeat (4) @(negedge clk);
    measure(64, h0, h1, bg, sg);
    check("R6", h0, 32, "RZ at divide 1 acts as NRZ");

    // R6: divide 8, write mid-tick
    do_reset(2'd3, 1'b0);
    repeat (3) @(negedge clk);
    write_code(0, 16'h2000);
    write_code(1, 16'h6000);
    repeat (40) @(negedge clk);
    measure(512, h0, h1, bg, sg);
    check("R6", h0, 64, "divide 8 high clocks ch0");
    check("R6", h1, 192, "divide 8 high clocks ch1");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule